// File: doc/BRIEF.md
# Dual-Format Parallel-to-Serial Transmit Serializer

This block turns parallel transmit data into a single serial bitstream, one bit per fast clock. It accepts either of two input formats, selected at run time. In full-word format, every accepted beat carries a complete 10-bit word. In half-word format, the block models a dual-edge capture as a 5-bit stream running at twice the word rate. A phase flag on each beat says which half of the word the beat carries.

Assembled words pass through a one-word holding register into a shift register. The shift register emits the least significant bit first. While one word is shifting out, the next word can wait in the holding register, so consecutive words leave with no idle cycle between them.

A loopback-enable input models the point where the line driver goes to high impedance. While it is high, the output is disabled and no bits are presented.

The input side is a valid/ready stream. The sender holds `in_valid`, `in_data` and `in_phase` steady until it sees `in_ready` high at a rising clock edge. `in_ready` is low whenever the holding register is occupied. It is also low for one cycle whenever the format select changes.

Top module: `dual_fmt_serializer`

## Requirements
- R1: After reset, `ser_valid` is 0, `ser_oe` is 1 (with `loop_en` low), and `in_ready` is 1.
- R2: With `fmt_sel` = 0 (full-word format), each accepted beat forms one 10-bit word equal to `in_data[9:0]`.
- R3: Every word is sent least significant bit first: word bit 0 appears first on `ser_bit`, and bit 9 appears last.
- R4: With `fmt_sel` = 1 (half-word format), a beat with `in_phase` = 1 supplies word bits [9:5] from `in_data[4:0]`. The next beat with `in_phase` = 0 supplies word bits [4:0] from `in_data[4:0]` and completes the word.
- R5: In half-word format, `in_data[9:5]` has no effect on the transmitted bits.
- R6: In half-word format, a beat with `in_phase` = 0 and no stored upper half produces no word. A second `in_phase` = 1 beat replaces the stored upper half.
- R7: Each word yields exactly 10 consecutive `ser_valid` cycles. A word already waiting when the previous word ends starts in the very next cycle, with no gap.
- R8: While a word waits in the holding register, `in_ready` is 0. No accepted word is lost or overwritten.
- R9: A change of `fmt_sel` drops `in_ready` for one cycle and discards any stored upper half. Later beats follow the new format.
- R10: While `loop_en` is 1, `ser_oe`, `ser_valid` and `ser_bit` are all 0. Words that shift out during that time are not presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 1 | 0 = full-word format, 1 = half-word format |
| loop_en | input | 1 | 1 disables the serial output |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_phase | input | 1 | Half-word format: 1 = upper half, 0 = lower half |
| in_data | input | 10 | Beat data (only bits [4:0] used in half-word format) |
| ser_bit | output | 1 | Serial data bit |
| ser_valid | output | 1 | `ser_bit` carries a data bit this cycle |
| ser_oe | output | 1 | Output enable (0 models high impedance) |

## Verification
The hardest case is a format change while an upper half is stored. Reaching it takes an `in_phase` = 1 beat in half-word format, then a change of `fmt_sel` before the matching lower half arrives. The stimulus then sends a full-word beat and, after switching back, a lone lower half. Only the full word may appear on the line. Gapless output is reached by queueing words faster than they drain, so that `in_ready` stalls the sender.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int DEF_WORD_W = 10;

  typedef enum logic {
    FMT_FULL = 1'b0,
    FMT_HALF = 1'b1
  } fmt_e;
endpackage

// File: rtl/ser_word_assembler.sv
module ser_word_assembler
  import ser_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  localparam int HALF_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt_sel,
  input  logic              beat_fire,
  input  logic              beat_phase,
  input  logic [WORD_W-1:0] beat_data,
  output logic              fmt_change,
  output logic              act_fmt,
  output logic              hi_pend,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data
);
  fmt_e              cur_fmt;
  logic [HALF_W-1:0] hi_half;

  assign act_fmt    = cur_fmt;
  assign fmt_change = (fmt_sel != cur_fmt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_fmt <= FMT_FULL;
      hi_pend <= 1'b0;
      hi_half <= '0;
    end else if (fmt_change) begin
      cur_fmt <= fmt_e'(fmt_sel);
      hi_pend <= 1'b0;
    end else if (beat_fire && cur_fmt == FMT_HALF) begin
      if (beat_phase) begin
        hi_pend <= 1'b1;
        hi_half <= beat_data[HALF_W-1:0];
      end else begin
        hi_pend <= 1'b0;
      end
    end
  end

  always_comb begin
    if (cur_fmt == FMT_FULL) begin
      word_valid = beat_fire;
      word_data  = beat_data;
    end else begin
      word_valid = beat_fire && !beat_phase && hi_pend;
      word_data  = {hi_half, beat_data[HALF_W-1:0]};
    end
  end
endmodule

// File: rtl/ser_hold_buf.sv
module ser_hold_buf
  import ser_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_take,
  output logic              full,
  output logic [WORD_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= 1'b0;
      rd_data <= '0;
    end else if (wr_en) begin
      full    <= 1'b1;
      rd_data <= wr_data;
    end else if (rd_take) begin
      full    <= 1'b0;
    end
  end
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter
  import ser_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  localparam int CNT_W = $clog2(WORD_W),
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_full,
  input  logic [WORD_W-1:0] src_data,
  output logic              take,
  output logic              busy,
  output logic [CNT_W-1:0]  cnt,
  output logic              bit_out
);
  logic [WORD_W-1:0] sreg;

  assign take    = src_full && (!busy || cnt == LAST);
  assign bit_out = sreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (take) begin
      sreg <= src_data;
      cnt  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      sreg <= sreg >> 1;
      cnt  <= cnt + 1'b1;
      if (cnt == LAST) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_fmt_serializer.sv
module dual_fmt_serializer
  import ser_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt_sel,
  input  logic              loop_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_phase,
  input  logic [WORD_W-1:0] in_data,
  output logic              ser_bit,
  output logic              ser_valid,
  output logic              ser_oe
);
  logic              fmt_change, act_fmt, hi_pend;
  logic              word_valid;
  logic [WORD_W-1:0] word_data;
  logic              hold_full;
  logic [WORD_W-1:0] hold_data;
  logic              take, busy, sh_bit;
  logic [CNT_W-1:0]  cnt;
  logic              beat_fire;

  assign in_ready  = !hold_full && !fmt_change;
  assign beat_fire = in_valid && in_ready;

  ser_word_assembler #(.WORD_W(WORD_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
    .beat_fire(beat_fire), .beat_phase(in_phase), .beat_data(in_data),
    .fmt_change(fmt_change), .act_fmt(act_fmt), .hi_pend(hi_pend),
    .word_valid(word_valid), .word_data(word_data)
  );

  ser_hold_buf #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(word_valid), .wr_data(word_data),
    .rd_take(take), .full(hold_full), .rd_data(hold_data)
  );

  ser_shifter #(.WORD_W(WORD_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .src_full(hold_full), .src_data(hold_data),
    .take(take), .busy(busy), .cnt(cnt), .bit_out(sh_bit)
  );

  assign ser_oe    = !loop_en;
  assign ser_valid = busy && !loop_en;
  assign ser_bit   = busy && !loop_en && sh_bit;
endmodule

// File: rtl/ser_checker.sv
module ser_checker #(
  parameter int WORD_W = 10,
  localparam int CNT_W = $clog2(WORD_W),
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fmt_sel,
  input logic             loop_en,
  input logic             in_valid,
  input logic             in_ready,
  input logic             act_fmt,
  input logic             hold_full,
  input logic             take,
  input logic             busy,
  input logic [CNT_W-1:0] cnt,
  input logic             ser_bit,
  input logic             ser_valid,
  input logic             ser_oe
);
  AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (!ser_valid && !ser_bit && !ser_oe)); // R10
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !take) |=> hold_full); // R8
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full |-> !in_ready); // R8
  AST_FMT_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_sel != act_fmt) |-> !in_ready); // R9
  AST_RUN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != LAST) |=> (busy && cnt == $past(cnt) + 1'b1)); // R7
  AST_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == LAST && hold_full) |=> (busy && cnt == '0)); // R7
  AST_FULL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !act_fmt) |=> hold_full); // R2
endmodule

bind dual_fmt_serializer ser_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .loop_en(loop_en),
  .in_valid(in_valid), .in_ready(in_ready), .act_fmt(act_fmt),
  .hold_full(hold_full), .take(take), .busy(busy), .cnt(cnt),
  .ser_bit(ser_bit), .ser_valid(ser_valid), .ser_oe(ser_oe)
);

// File: tb/tb_dual_fmt_serializer.sv
`timescale 1ns/100ps
module tb_dual_fmt_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fmt_sel = 1'b0;
  logic       loop_en = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_phase = 1'b0;
  logic [9:0] in_data = '0;
  logic       ser_bit, ser_valid, ser_oe;

  int   n_chk = 0;
  int   n_bad = 0;
  int   bursts = 0;
  int   stalls = 0;
  logic prev_v = 1'b0;
  bit   got[$];
  bit   exp[$];

  always #2.5 clk = ~clk;

  dual_fmt_serializer dut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .loop_en(loop_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_phase(in_phase),
    .in_data(in_data), .ser_bit(ser_bit), .ser_valid(ser_valid), .ser_oe(ser_oe)
  );

  always @(posedge clk) begin
    #2;
    if (ser_valid) got.push_back(ser_bit);
    if (ser_valid && !prev_v) bursts++;
    prev_v = ser_valid;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
    summary();
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic clear_mon();
    got.delete(); exp.delete(); bursts = 0; stalls = 0;
  endtask

  task automatic expect_word(input logic [9:0] w);
    for (int i = 0; i < 10; i++) exp.push_back(w[i]);
  endtask

  // entered and left at a falling edge
  task automatic put(input logic [9:0] d, input logic ph);
    in_valid = 1'b1; in_data = d; in_phase = ph; #1;
    while (!in_ready) begin
      stalls++;
      @(negedge clk); #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic compare(input string req);
    int mism = 0;
    chk(got.size() == exp.size(), req, got.size(), exp.size());
    if (got.size() == exp.size())
      for (int i = 0; i < got.size(); i++) if (got[i] != exp[i]) mism++;
    chk(mism == 0, req, mism, 0);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(ser_valid == 1'b0, "R1 ser_valid", ser_valid, 0);
    chk(ser_oe == 1'b1, "R1 ser_oe", ser_oe, 1);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic t_full_stream();
    clear_mon();
    put(10'h2A5, 0); expect_word(10'h2A5);
    put(10'h0F3, 1); expect_word(10'h0F3);
    put(10'h301, 0); expect_word(10'h301);
    idle(40);
    compare("R2 R3 full-word stream order");
    chk(bursts == 1, "R7 single gapless burst", bursts, 1);
    chk(stalls > 0, "R8 sender stalled while word held", stalls, 1);
  endtask

  task automatic t_half();
    clear_mon();
    fmt_sel = 1'b1; idle(2);
    put({5'h1F, 5'h13}, 1);
    put({5'h15, 5'h0A}, 0); expect_word({5'h13, 5'h0A});
    put({5'h00, 5'h1C}, 1);
    put({5'h1F, 5'h07}, 0); expect_word({5'h1C, 5'h07});
    idle(30);
    compare("R4 R5 half-word assembly, upper bits ignored");
  endtask

  task automatic t_orphan();
    clear_mon();
    put(10'h011, 0);
    idle(15);
    chk(got.size() == 0, "R6 lone lower half dropped", got.size(), 0);
    put(10'h005, 1);
    put(10'h019, 1);
    put(10'h00E, 0); expect_word({5'h19, 5'h0E});
    put(10'h003, 0);
    idle(30);
    compare("R6 replaced upper half, extra lower half dropped");
  endtask

  task automatic t_fmt_change();
    clear_mon();
    put(10'h01B, 1);
    fmt_sel = 1'b0; #1;
    chk(in_ready == 1'b0, "R9 ready low on format change", in_ready, 0);
    @(negedge clk);
    put(10'h1C6, 0); expect_word(10'h1C6);
    fmt_sel = 1'b1; @(negedge clk);
    put(10'h004, 0);
    idle(30);
    compare("R9 pending half discarded across format change");
  endtask

  task automatic t_loop();
    clear_mon();
    fmt_sel = 1'b0; idle(2);
    loop_en = 1'b1; #1;
    chk(ser_oe == 1'b0, "R10 output disabled", ser_oe, 0);
    @(negedge clk);
    put(10'h3C3, 0);
    idle(5); #1;
    chk(ser_bit == 1'b0 && ser_valid == 1'b0, "R10 quiet while disabled", ser_valid, 0);
    idle(15);
    chk(got.size() == 0, "R10 no bits presented", got.size(), 0);
    loop_en = 1'b0; #1;
    chk(ser_oe == 1'b1, "R10 output re-enabled", ser_oe, 1);
    @(negedge clk);
    put(10'h15A, 0); expect_word(10'h15A);
    idle(20);
    compare("R10 stream after loopback released");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_stream();
    t_half();
    t_orphan();
    t_fmt_change();
    t_loop();
    summary();
  end
endmodule